// File: doc/BRIEF.md
# Disc Block Address to Minute:Second:Frame Converter

This block turns a linear optical-disc block address into the minute, second and frame triple that disc table-of-contents entries carry. Before splitting, it adds a fixed lead-in offset of 150 frames. The split counts 75 frames per second and 60 seconds per minute. A second mode skips the conversion. In that mode the raw address is returned as a big-endian 32-bit word spread over four byte outputs.

A one-cycle `start` pulse captures the address and the mode. The block then reports `busy` while it works and raises `done` for exactly one cycle when the result is ready. The division is not combinational. A single shared trial-subtract stage first produces the minute count against 4500 frames per minute, one quotient bit per cycle. The same stage then produces the second count against 75 frames per second, and the final remainder is the frame number. An adjusted address of 256 minutes or more is reported as an overflow with saturated fields.

Top module: `msf_conv`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `range_ovf` are 0 and all four byte outputs are 0.
- R2: When `start` is high in a cycle where `busy` is 0, the clock edge captures `blk_addr` and `pack_mode`, and `busy` is 1 in the following cycle.
- R3: In conversion mode (`pack_mode`=0), with adj = `blk_addr` + 150, `byte0` holds adj mod 75 when `done` is high.
- R4: In conversion mode, `byte1` holds (adj div 75) mod 60 when `done` is high.
- R5: In conversion mode, `byte2` holds adj div 4500 when `done` is high, and `byte3` is 0.
- R6: In conversion mode, if adj is 1152000 or more (256 minutes), `range_ovf` is 1 and the fields saturate to `byte2`=255, `byte1`=59, `byte0`=74. Otherwise `range_ovf` is 0.
- R7: In packed mode (`pack_mode`=1), no offset is applied. {`byte3`,`byte2`,`byte1`,`byte0`} equals the 24-bit address zero-extended to 32 bits, with the most significant byte in `byte3`, and `range_ovf` is 0.
- R8: `done` is high for one cycle only. After it falls, the byte outputs and `range_ovf` keep their values until the next accepted start.
- R9: `start` is ignored while `busy` is 1. It produces no extra `done` and does not change the pending result.
- R10: `done` goes high after the 15th rising edge, counted from and including the edge that accepts `start`, for an in-range conversion. For packed mode or overflow it goes high after the first such edge. `busy` never lasts 40 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse; captures address and mode when idle |
| pack_mode | input | 1 | 0 = minute:second:frame, 1 = big-endian packed address |
| blk_addr | input | 24 | Linear block address |
| busy | output | 1 | Conversion in progress, start ignored |
| done | output | 1 | One-cycle result-valid pulse |
| range_ovf | output | 1 | Adjusted address beyond 255 minutes |
| byte3 | output | 8 | Most significant result byte (0 in conversion mode) |
| byte2 | output | 8 | Minutes, or address bits 23:16 |
| byte1 | output | 8 | Seconds, or address bits 15:8 |
| byte0 | output | 8 | Frames, or address bits 7:0 |

## Verification
On every cycle, the embedded properties check several things: `done` is a single-cycle pulse, an idle start always raises `busy`, and a start seen while busy leaves the captured mode and overflow untouched. They also check that a converted result always has seconds below 60 and frames below 75, that overflow always shows 255 minutes, and that `busy` stays under the latency bound. The numeric correctness of each field can only be shown by the scoreboard scenarios, which compare against independently computed values. These cover the 59:74 to next-minute rollover, the last in-range address, the first overflowing address and packed words. The scenarios also show that the outputs hold after `done` and that a start issued mid-conversion leaves no trace.

// File: rtl/msf_pkg.sv
package msf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MIN  = 2'd1,
    ST_SEC  = 2'd2,
    ST_FIN  = 2'd3
  } conv_state_e;

endpackage

// File: rtl/msf_rst_sync.sv
module msf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/msf_range_chk.sv
module msf_range_chk #(
  parameter int ADDR_W  = 24,
  parameter int REM_W   = 25,
  parameter int LEAD_IN = 150,
  parameter int LIMIT   = 1152000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              pack,
  output logic [REM_W-1:0]  load_val,
  output logic              ovf
);

  localparam logic [REM_W-1:0] LEAD_V  = REM_W'(LEAD_IN);
  localparam logic [REM_W-1:0] LIMIT_V = REM_W'(LIMIT);

  logic [REM_W-1:0] adj;

  always_comb begin
    adj      = REM_W'(addr) + LEAD_V;
    load_val = pack ? REM_W'(addr) : adj;
    ovf      = !pack && (adj >= LIMIT_V);
  end

endmodule

// File: rtl/msf_div_step.sv
module msf_div_step #(
  parameter int W = 25
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] dvs,
  output logic         take,
  output logic [W-1:0] rem_out
);

  logic [W:0] diff;

  always_comb begin
    diff    = {1'b0, rem_in} - {1'b0, dvs};
    take    = !diff[W];
    rem_out = take ? diff[W-1:0] : rem_in;
  end

endmodule

// File: rtl/msf_conv.sv
module msf_conv
  import msf_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEAD_IN = 150,
  parameter int FPS     = 75,
  parameter int SPM     = 60,
  parameter int MIN_W   = 8,
  parameter int LAT_MAX = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pack_mode,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic              busy,
  output logic              done,
  output logic              range_ovf,
  output logic [7:0]        byte3,
  output logic [7:0]        byte2,
  output logic [7:0]        byte1,
  output logic [7:0]        byte0
);

  localparam int FPM      = FPS * SPM;
  localparam int REM_W    = ADDR_W + 1;
  localparam int SEC_W    = $clog2(SPM);
  localparam int FRM_W    = $clog2(FPS);
  localparam int LIMIT    = FPM << MIN_W;
  localparam int STEP_MAX = (MIN_W > SEC_W) ? MIN_W : SEC_W;
  localparam int CNT_W    = $clog2(STEP_MAX + 1);
  localparam int LAT_W    = $clog2(LAT_MAX + 2);

  logic rst_sync_n;

  msf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // state registers
  conv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [MIN_W-1:0] qmin_q, qmin_d;
  logic [SEC_W-1:0] qsec_q, qsec_d;
  logic             ovf_q, ovf_d;
  logic             pack_q, pack_d;
  logic             reg_en;

  // capture path
  logic [REM_W-1:0] load_val;
  logic             load_ovf;

  msf_range_chk #(
    .ADDR_W  (ADDR_W),
    .REM_W   (REM_W),
    .LEAD_IN (LEAD_IN),
    .LIMIT   (LIMIT)
  ) u_range (
    .addr     (blk_addr),
    .pack     (pack_mode),
    .load_val (load_val),
    .ovf      (load_ovf)
  );

  // shared trial-subtract stage
  logic [REM_W-1:0] step_dvs;
  logic [REM_W-1:0] step_rem;
  logic             step_take;

  always_comb begin
    if (state_q == ST_SEC) step_dvs = REM_W'(FPS) << cnt_q;
    else                   step_dvs = REM_W'(FPM) << cnt_q;
  end

  msf_div_step #(
    .W (REM_W)
  ) u_step (
    .rem_in  (rem_q),
    .dvs     (step_dvs),
    .take    (step_take),
    .rem_out (step_rem)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    qmin_d  = qmin_q;
    qsec_d  = qsec_q;
    ovf_d   = ovf_q;
    pack_d  = pack_q;
    reg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          reg_en  = 1'b1;
          rem_d   = load_val;
          ovf_d   = load_ovf;
          pack_d  = pack_mode;
          qmin_d  = '0;
          qsec_d  = '0;
          cnt_d   = CNT_W'(MIN_W - 1);
          state_d = (pack_mode || load_ovf) ? ST_FIN : ST_MIN;
        end
      end
      ST_MIN: begin
        reg_en = 1'b1;
        rem_d  = step_rem;
        qmin_d = {qmin_q[MIN_W-2:0], step_take};
        if (cnt_q == '0) begin
          cnt_d   = CNT_W'(SEC_W - 1);
          state_d = ST_SEC;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SEC: begin
        reg_en = 1'b1;
        rem_d  = step_rem;
        qsec_d = {qsec_q[SEC_W-2:0], step_take};
        if (cnt_q == '0) state_d = ST_FIN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_FIN: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      qmin_q  <= '0;
      qsec_q  <= '0;
      ovf_q   <= 1'b0;
      pack_q  <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      qmin_q  <= qmin_d;
      qsec_q  <= qsec_d;
      ovf_q   <= ovf_d;
      pack_q  <= pack_d;
    end
  end

  // output formatting
  logic [7:0]  min_f, sec_f, frm_f;
  logic [31:0] word_f;

  always_comb begin
    min_f = ovf_q ? 8'hFF          : 8'(qmin_q);
    sec_f = ovf_q ? 8'(SPM - 1)    : 8'(qsec_q);
    frm_f = ovf_q ? 8'(FPS - 1)    : 8'(rem_q[FRM_W-1:0]);
    if (pack_q) word_f = 32'(rem_q[ADDR_W-1:0]);
    else        word_f = {8'h00, min_f, sec_f, frm_f};
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign range_ovf = ovf_q;
  assign byte3     = word_f[31:24];
  assign byte2     = word_f[23:16];
  assign byte1     = word_f[15:8];
  assign byte0     = word_f[7:0];

  // busy-length counter used by the latency property
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)           lat_q <= '0;
    else if (!busy)            lat_q <= '0;
    else if (lat_q != '1)      lat_q <= lat_q + 1'b1;
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start) |=> busy);

  p_field_range_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !pack_q) |-> (byte1 < 8'(SPM) && byte0 < 8'(FPS)));

  p_sat_min_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && range_ovf) |-> (byte2 == 8'hFF));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> ($stable(pack_q) && $stable(ovf_q)));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> (lat_q < LAT_W'(LAT_MAX)));

endmodule

// File: tb/msf_conv_tb.sv
`timescale 1ns/1ps
module msf_conv_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        pack_mode;
  logic [23:0] blk_addr;
  logic        busy, done, range_ovf;
  logic [7:0]  byte3, byte2, byte1, byte0;

  msf_conv u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pack_mode (pack_mode),
    .blk_addr  (blk_addr),
    .busy      (busy),
    .done      (done),
    .range_ovf (range_ovf),
    .byte3     (byte3),
    .byte2     (byte2),
    .byte1     (byte1),
    .byte0     (byte0)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] word;
    logic        ovf;
    logic        pack;
    int unsigned lat;
    int unsigned icyc;
  } exp_t;

  exp_t exp_q[$];

  int errors = 0;
  int checks = 0;
  int extra_done = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: computes expectation from the requirements and pushes it
  task automatic issue(input logic [23:0] a, input logic pk);
    exp_t e;
    int unsigned adj;
    adj = 32'(a) + 150;
    e.pack = pk;
    if (pk) begin
      e.word = {8'h00, a};
      e.ovf  = 1'b0;
      e.lat  = 1;
    end else if (adj >= 1152000) begin
      e.word = {8'h00, 8'd255, 8'd59, 8'd74};
      e.ovf  = 1'b1;
      e.lat  = 1;
    end else begin
      e.word = {8'h00, 8'(adj / 4500), 8'((adj / 75) % 60), 8'(adj % 75)};
      e.ovf  = 1'b0;
      e.lat  = 15;
    end
    @(negedge clk);
    blk_addr  = a;
    pack_mode = pk;
    start     = 1'b1;
    e.icyc    = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    wait (exp_q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expectations and compares
  logic [31:0] held_word;
  logic        held_ovf;
  bit          hold_chk = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          extra_done++;
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          logic [31:0] w;
          e = exp_q.pop_front();
          w = {byte3, byte2, byte1, byte0};
          if (e.pack) begin
            chk(w == e.word, "R7 packed word", longint'(w), longint'(e.word));
          end else if (e.ovf) begin
            chk(w == e.word, "R6 saturated fields", longint'(w), longint'(e.word));
          end else begin
            chk(byte3 == 8'h00 && byte2 == e.word[23:16], "R5 minutes",
                longint'({byte3, byte2}), longint'(e.word[23:16]));
            chk(byte1 == e.word[15:8], "R4 seconds", longint'(byte1), longint'(e.word[15:8]));
            chk(byte0 == e.word[7:0], "R3 frames", longint'(byte0), longint'(e.word[7:0]));
          end
          chk(range_ovf == e.ovf, "R6 overflow flag", longint'(range_ovf), longint'(e.ovf));
          chk(cyc - e.icyc == e.lat, "R10 latency", longint'(cyc - e.icyc), longint'(e.lat));
          held_word = w;
          held_ovf  = range_ovf;
          hold_chk  = 1'b1;
        end
      end else if (hold_chk) begin
        hold_chk = 1'b0;
        chk(done == 1'b0, "R8 done pulse width", longint'(done), 0);
        chk({byte3, byte2, byte1, byte0} == held_word && range_ovf == held_ovf,
            "R8 outputs held", longint'({byte3, byte2, byte1, byte0}), longint'(held_word));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    start     = 1'b0;
    pack_mode = 1'b0;
    blk_addr  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !range_ovf && {byte3, byte2, byte1, byte0} == 32'h0,
        "R1 reset state", longint'({byte3, byte2, byte1, byte0}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !range_ovf && {byte3, byte2, byte1, byte0} == 32'h0,
        "R1 state after release", longint'({busy, done, range_ovf}), 0);
    mon_on = 1'b1;

    // R3 R4 R5: conversion corners
    issue(24'd0, 1'b0);          // 0:02:00
    issue(24'd4349, 1'b0);       // 0:59:74
    issue(24'd4350, 1'b0);       // 1:00:00
    issue(24'd74, 1'b0);         // 0:02:74
    issue(24'd123456, 1'b0);
    issue(24'd1151849, 1'b0);    // 255:59:74 no overflow
    // R6: overflow boundary and extreme
    issue(24'd1151850, 1'b0);
    issue(24'hFFFFFF, 1'b0);
    // R7: packed mode
    issue(24'h123456, 1'b1);
    issue(24'hFFFFFF, 1'b1);
    issue(24'h000001, 1'b1);

    // mixed pseudo-random vectors
    begin
      logic [31:0] s;
      s = 32'h1ACE5EED;
      for (int i = 0; i < 12; i++) begin
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        if (i % 3 == 2) issue(s[23:0], 1'b1);
        else            issue(24'(s % 32'd1200000), 1'b0);
      end
    end

    // R9: start while busy is ignored
    begin
      exp_t e;
      int unsigned adj;
      adj    = 32'd200000 + 150;
      e.pack = 1'b0;
      e.ovf  = 1'b0;
      e.lat  = 15;
      e.word = {8'h00, 8'(adj / 4500), 8'((adj / 75) % 60), 8'(adj % 75)};
      @(negedge clk);
      blk_addr  = 24'd200000;
      pack_mode = 1'b0;
      start     = 1'b1;
      e.icyc    = cyc;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      blk_addr  = 24'hABCDEF;
      pack_mode = 1'b1;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait (exp_q.size() == 0);
      repeat (25) @(negedge clk);
      chk(extra_done == 0, "R9 no extra result", longint'(extra_done), 0);
    end
    issue(24'd9000, 1'b0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule